// File: doc/BRIEF.md
# Display Readout Sequencer with Source Mux

This block runs the readout of display memory into the horizontal and vertical DACs. A host writes registers through a small select-decoded write port: a start address that is latched straight into the display counter, a stop address, a mode word, two cursor values, and a control word whose bit 0 is the start strobe. The strobe wakes a four-state sequencer (idle, arm, run, done). While it runs, the sequencer takes the display-memory address bus away from the waveform processor and lets each display-clock tick advance the counter by one.

Display memory sits outside the block. Its three regions (vertical, horizontal, attribute) return data one clock after a read. The output stage delays the read address by that same cycle. It then picks, from the mode word, the byte for each DAC. In YT mode the horizontal DAC gets the low bits of the read address, so successive reads draw a staircase ramp. In XY mode it gets horizontal-region data. The vertical DAC takes the region or cursor chosen by a three-bit source code. The sequence stops after the read at the stop address. The bus then goes back to the processor and `done` pulses for one clock.

Top module: `disp_readout_seq`

## Requirements
- R1: After reset the sequencer is idle: `seq_owns` and `dm_rd`, `dac_valid` and `done` are low, and `dm_addr` equals `wp_addr`.
- R2: A write with `host_sel`=0 loads `host_wdata[ADDR_W-1:0]` into the display counter when the sequencer is idle or done, and the first read of the next sequence uses that address.
- R3: A write with `host_sel`=3 and `host_wdata[0]`=1 while idle or done moves to an arm cycle. In that cycle, right after the write edge, `seq_owns` is high, `dm_rd` is low and `dm_addr` shows the counter. Run follows on the next edge.
- R4: In run, `dm_rd` equals `disp_tick`. Each read advances the counter by exactly one, modulo 2^ADDR_W. Without a tick the counter holds.
- R5: The read at the stop address (`host_sel`=1) is the last one. `done` is then high for exactly one cycle with `seq_owns` low and `dm_addr` equal to `wp_addr`. No further read follows without a new strobe.
- R6: A strobe or a start-address write that arrives during arm or run is ignored. This includes a strobe that falls on the same clock as the final read.
- R7: `dac_valid` is high exactly in the cycle after each read. In YT mode (`host_sel`=2, bit 3 = 0), `hdac` then equals the low DATA_W bits of the address that was read.
- R8: In XY mode (mode bit 3 = 1), `hdac` carries the horizontal-region byte of the address that was read.
- R9: The mode bits [2:0] pick the vertical DAC source: 0 vertical region, 1 horizontal region, 2 attribute region, 3 volts cursor, 4 time cursor. Codes 5 to 7 act as 0.
- R10: The volts cursor (`host_sel`=4) and the time cursor (`host_sel`=5) hold the low DATA_W bits of their last write. When selected, they appear on `vdac`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write enable |
| host_sel | input | 3 | Host register select |
| host_wdata | input | HOST_W | Host write data |
| disp_tick | input | 1 | Display clock enable, one pulse per display clock |
| wp_addr | input | ADDR_W | Waveform processor address to display memory |
| dm_addr | output | ADDR_W | Display memory address after the address multiplexer |
| dm_rd | output | 1 | Display memory read strobe from the sequencer |
| seq_owns | output | 1 | The sequencer drives the display memory address bus |
| vram_q | input | DATA_W | Vertical region read data, one cycle after the read |
| hram_q | input | DATA_W | Horizontal region read data, one cycle after the read |
| aram_q | input | DATA_W | Attribute region read data, one cycle after the read |
| hdac | output | DATA_W | Horizontal DAC code |
| vdac | output | DATA_W | Vertical DAC code |
| dac_valid | output | 1 | DAC codes are valid this cycle |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The final tick of a run and a new host start strobe can land on the same clock edge. The stop test and the restart test then compete. The bench waits until it sees the read of the stop address at a falling edge. In that same cycle it drives a control write with the strobe bit set. A correct design finishes with one `done` pulse, lets go of the bus, and issues no more reads. The bench judges this by `done` and `seq_owns` on the next cycles and by the scoreboard, which rejects any output it does not expect.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_VERT = 3'd0,
        SRC_HORZ = 3'd1,
        SRC_ATTR = 3'd2,
        SRC_VCUR = 3'd3,
        SRC_TCUR = 3'd4
    } vsrc_e;

    typedef enum logic [2:0] {
        REG_START = 3'd0,
        REG_STOP  = 3'd1,
        REG_MODE  = 3'd2,
        REG_CTRL  = 3'd3,
        REG_VCUR  = 3'd4,
        REG_TCUR  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic  xy;
        vsrc_e vsrc;
    } mode_t;

    // bits [2:0] vertical source, bit 3 XY routing; unknown codes fall back to vertical
    function automatic mode_t decode_mode(input logic [3:0] w);
        mode_t m;
        m.xy = w[3];
        if (w[2:0] > 3'd4) m.vsrc = SRC_VERT;
        else               m.vsrc = vsrc_e'(w[2:0]);
        return m;
    endfunction

endpackage

// File: rtl/drs_hostregs.sv
module drs_hostregs
    import drs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [HOST_W-1:0] wdata,
    output logic              ld_en,
    output logic [ADDR_W-1:0] ld_val,
    output logic              strobe,
    output logic [ADDR_W-1:0] stop_q,
    output mode_t             mode_q,
    output logic [DATA_W-1:0] vcur_q,
    output logic [DATA_W-1:0] tcur_q
);

    localparam int SPARE_W = HOST_W - ADDR_W;

    logic unused_hi;
    generate
        if (SPARE_W > 0) begin : g_spare
            assign unused_hi = ^wdata[HOST_W-1:ADDR_W];
        end else begin : g_nospare
            assign unused_hi = 1'b0;
        end
    endgenerate

    // start address goes straight to the counter; no copy is kept here
    assign ld_en  = we && (sel == REG_START);
    assign ld_val = wdata[ADDR_W-1:0];
    assign strobe = we && (sel == REG_CTRL) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= '0;
            mode_q <= decode_mode(4'd0);
            vcur_q <= '0;
            tcur_q <= '0;
        end else if (we) begin
            case (sel)
                REG_STOP: stop_q <= wdata[ADDR_W-1:0];
                REG_MODE: mode_q <= decode_mode(wdata[3:0]);
                REG_VCUR: vcur_q <= wdata[DATA_W-1:0];
                REG_TCUR: tcur_q <= wdata[DATA_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/drs_seq.sv
module drs_seq
    import drs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic              tick,
    output logic [ADDR_W-1:0] cnt,
    output logic              owns,
    output logic              rd,
    output logic              fin
);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (ld_en) cnt <= ld_val;
                    state <= strobe ? ST_ARM : ST_IDLE;
                end
                ST_ARM: state <= ST_RUN;
                ST_RUN: begin
                    if (tick) begin
                        if (cnt == stop_addr) state <= ST_DONE;
                        else                  cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign owns = (state == ST_ARM) || (state == ST_RUN);
    assign rd   = (state == ST_RUN) && tick;
    assign fin  = (state == ST_DONE);

endmodule

// File: rtl/drs_route.sv
module drs_route
    import drs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [DATA_W-1:0] ramp_in,
    input  mode_t             mode,
    input  logic [DATA_W-1:0] vram,
    input  logic [DATA_W-1:0] hram,
    input  logic [DATA_W-1:0] aram,
    input  logic [DATA_W-1:0] vcur,
    input  logic [DATA_W-1:0] tcur,
    output logic [DATA_W-1:0] hout,
    output logic [DATA_W-1:0] vout,
    output logic              valid
);

    logic [DATA_W-1:0] ramp_q;

    // memory answers one cycle after the read, so the ramp is held one cycle too
    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            ramp_q <= '0;
        end else begin
            valid <= rd;
            if (rd) ramp_q <= ramp_in;
        end
    end

    assign hout = mode.xy ? hram : ramp_q;

    always_comb begin
        case (mode.vsrc)
            SRC_HORZ: vout = hram;
            SRC_ATTR: vout = aram;
            SRC_VCUR: vout = vcur;
            SRC_TCUR: vout = tcur;
            default:  vout = vram;
        endcase
    end

endmodule

// File: rtl/disp_readout_seq.sv
module disp_readout_seq
    import drs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              disp_tick,
    input  logic [ADDR_W-1:0] wp_addr,
    output logic [ADDR_W-1:0] dm_addr,
    output logic              dm_rd,
    output logic              seq_owns,
    input  logic [DATA_W-1:0] vram_q,
    input  logic [DATA_W-1:0] hram_q,
    input  logic [DATA_W-1:0] aram_q,
    output logic [DATA_W-1:0] hdac,
    output logic [DATA_W-1:0] vdac,
    output logic              dac_valid,
    output logic              done
);

    logic              ld_en;
    logic [ADDR_W-1:0] ld_val;
    logic              strobe;
    logic [ADDR_W-1:0] stop_q;
    mode_t             mode_q;
    logic [DATA_W-1:0] vcur_q;
    logic [DATA_W-1:0] tcur_q;
    logic [ADDR_W-1:0] cnt;
    logic              mode_xy;

    drs_hostregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_W(HOST_W)) u_regs (
        .clk(clk), .rst(rst), .we(host_we), .sel(host_sel), .wdata(host_wdata),
        .ld_en(ld_en), .ld_val(ld_val), .strobe(strobe), .stop_q(stop_q),
        .mode_q(mode_q), .vcur_q(vcur_q), .tcur_q(tcur_q)
    );

    drs_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .strobe(strobe), .ld_en(ld_en), .ld_val(ld_val),
        .stop_addr(stop_q), .tick(disp_tick), .cnt(cnt), .owns(seq_owns),
        .rd(dm_rd), .fin(done)
    );

    // address multiplexer: counter while sequencing, processor otherwise
    assign dm_addr = seq_owns ? cnt : wp_addr;
    assign mode_xy = mode_q.xy;

    drs_route #(.DATA_W(DATA_W)) u_route (
        .clk(clk), .rst(rst), .rd(dm_rd), .ramp_in(cnt[DATA_W-1:0]), .mode(mode_q),
        .vram(vram_q), .hram(hram_q), .aram(aram_q), .vcur(vcur_q), .tcur(tcur_q),
        .hout(hdac), .vout(vdac), .valid(dac_valid)
    );

endmodule

// File: rtl/disp_readout_seq_chk.sv
module disp_readout_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int HOST_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [2:0]        host_sel,
    input logic [HOST_W-1:0] host_wdata,
    input logic [ADDR_W-1:0] wp_addr,
    input logic [ADDR_W-1:0] dm_addr,
    input logic              dm_rd,
    input logic              seq_owns,
    input logic              done,
    input logic              dac_valid,
    input logic [DATA_W-1:0] hdac,
    input logic              mode_xy
);

    logic go;
    logic unused_w;
    assign go       = host_we && (host_sel == 3'd3) && host_wdata[0];
    assign unused_w = ^host_wdata[HOST_W-1:1];

    p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
        !seq_owns |-> dm_addr == wp_addr);

    p_arm_after_go_r3: assert property (@(posedge clk) disable iff (rst)
        go && !seq_owns |=> seq_owns && !dm_rd);

    p_read_owned_r4: assert property (@(posedge clk) disable iff (rst)
        dm_rd |-> seq_owns);

    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        dm_rd |=> (!seq_owns || dm_addr == $past(dm_addr) + 1'b1));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_release_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !seq_owns && !dm_rd);

    p_go_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        go && seq_owns && !dm_rd |=> seq_owns);

    p_valid_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
        dm_rd |=> dac_valid);

    p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !dm_rd |=> !dac_valid);

    p_ramp_r7: assert property (@(posedge clk) disable iff (rst)
        dm_rd |=> (mode_xy || hdac == $past(dm_addr[DATA_W-1:0])));

endmodule

bind disp_readout_seq disp_readout_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_W(HOST_W)
) u_chk (.*);

// File: tb/sim_disp_readout_seq.sv
module sim_disp_readout_seq;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int HW = 16;

    typedef struct packed {
        logic [DW-1:0] h;
        logic [DW-1:0] v;
        logic [AW-1:0] a;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [2:0]    host_sel = '0;
    logic [HW-1:0] host_wdata = '0;
    logic          disp_tick = 1'b0;
    logic [AW-1:0] wp_addr = 10'h2AB;
    logic [AW-1:0] dm_addr;
    logic          dm_rd, seq_owns, dac_valid, done;
    logic [DW-1:0] vram_q = '0, hram_q = '0, aram_q = '0;
    logic [DW-1:0] hdac, vdac;

    int   n_checks = 0;
    int   n_errors = 0;
    int   phase = 0;
    bit   gated = 1'b0;
    bit   finished = 1'b0;
    logic [DW-1:0] vcur_m = '0, tcur_m = '0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    disp_readout_seq #(.ADDR_W(AW), .DATA_W(DW), .HOST_W(HW)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .disp_tick(disp_tick), .wp_addr(wp_addr),
        .dm_addr(dm_addr), .dm_rd(dm_rd), .seq_owns(seq_owns),
        .vram_q(vram_q), .hram_q(hram_q), .aram_q(aram_q),
        .hdac(hdac), .vdac(vdac), .dac_valid(dac_valid), .done(done)
    );

    function automatic logic [DW-1:0] fv(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = a * 7 + 3;
        return t[DW-1:0];
    endfunction
    function automatic logic [DW-1:0] fh(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 8'hA5;
    endfunction
    function automatic logic [DW-1:0] fa(input logic [AW-1:0] a);
        return ~a[DW-1:0] + 8'd17;
    endfunction

    // display memory model: one-cycle read latency
    always @(posedge clk) begin
        if (dm_rd) begin
            vram_q <= fv(dm_addr);
            hram_q <= fh(dm_addr);
            aram_q <= fa(dm_addr);
        end
    end

    // display clock: every cycle, or one in three when gated
    always @(negedge clk) begin
        phase     <= (phase == 2) ? 0 : phase + 1;
        disp_tick <= gated ? (phase == 0) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every valid DAC output
    always @(negedge clk) begin
        if (!rst && dac_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected dac output", {16'd0, hdac, vdac}, 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(hdac == e.h, "R7/R8", $sformatf("hdac at addr %0h", e.a), hdac, e.h);
                check(vdac == e.v, "R9/R10", $sformatf("vdac at addr %0h", e.a), vdac, e.v);
            end
        end
    end

    task automatic hw(input logic [2:0] s, input logic [HW-1:0] d);
        host_we    = 1'b1;
        host_sel   = s;
        host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    function automatic logic [DW-1:0] vexp(input logic [2:0] vs, input logic [AW-1:0] a);
        case (vs)
            3'd1: return fh(a);
            3'd2: return fa(a);
            3'd3: return vcur_m;
            3'd4: return tcur_m;
            default: return fv(a);
        endcase
    endfunction

    task automatic push_range(input logic [AW-1:0] s, input logic [AW-1:0] e,
                              input bit xy, input logic [2:0] vs);
        logic [AW-1:0] a;
        item_t it;
        a = s;
        forever begin
            it.a = a;
            it.h = xy ? fh(a) : a[DW-1:0];
            it.v = vexp(vs, a);
            exp_q.push_back(it);
            if (a == e) break;
            a = a + 1'b1;
        end
    endtask

    task automatic run_seq(input logic [AW-1:0] s, input logic [AW-1:0] e,
                           input bit xy, input logic [2:0] vs, input bit gt,
                           input bit interfere);
        gated = gt;
        hw(3'd0, HW'(s));
        hw(3'd1, HW'(e));
        hw(3'd2, HW'({xy, vs}));
        push_range(s, e, xy, vs);
        hw(3'd3, 16'h0001);
        check(seq_owns == 1'b1, "R3", "bus taken after strobe", seq_owns, 1);
        check(dm_rd == 1'b0, "R3", "no read in arm cycle", dm_rd, 0);
        check(dm_addr == s, "R2", "first address", dm_addr, s);
        if (interfere) begin
            @(negedge clk);
            hw(3'd0, 16'h0000);
            hw(3'd3, 16'h0001);
        end
        while (!done) @(negedge clk);
        check(dm_addr == wp_addr, "R5", "bus released at done", dm_addr, wp_addr);
        check(seq_owns == 1'b0, "R5", "not owning at done", seq_owns, 0);
        @(negedge clk);
        check(done == 1'b0, "R5", "done is one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all outputs seen", exp_q.size(), 0);
        check(seq_owns == 1'b0 && dm_rd == 1'b0, "R5", "stays idle", {seq_owns, dm_rd}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(seq_owns == 1'b0, "R1", "reset owner", seq_owns, 0);
        check(dm_rd == 1'b0, "R1", "reset read", dm_rd, 0);
        check(dac_valid == 1'b0 && done == 1'b0, "R1", "reset flags", {dac_valid, done}, 0);
        check(dm_addr == wp_addr, "R1", "reset mux", dm_addr, wp_addr);

        // R7 R9: YT ramp, vertical region, tick every cycle
        run_seq(10'd5, 10'd12, 1'b0, 3'd0, 1'b0, 1'b0);
        // R8 R4: XY, attribute region on vertical, gated tick
        run_seq(10'd100, 10'd107, 1'b1, 3'd2, 1'b1, 1'b0);
        // R10: volts cursor, ramp crosses the 8-bit wrap
        hw(3'd4, 16'h1234); vcur_m = 8'h34;
        run_seq(10'd250, 10'd260, 1'b0, 3'd3, 1'b0, 1'b0);
        // R10: time cursor, horizontal region choice in XY
        hw(3'd5, 16'h00C7); tcur_m = 8'hC7;
        run_seq(10'd30, 10'd33, 1'b0, 3'd4, 1'b1, 1'b0);
        run_seq(10'd60, 10'd63, 1'b1, 3'd1, 1'b0, 1'b0);
        // R9: undefined code acts as vertical region
        run_seq(10'd70, 10'd72, 1'b0, 3'd6, 1'b0, 1'b0);
        // R4: counter wraps modulo 2^AW
        run_seq(10'd1021, 10'd2, 1'b0, 3'd0, 1'b0, 1'b0);
        // single-address sequence
        run_seq(10'd500, 10'd500, 1'b1, 3'd0, 1'b0, 1'b0);
        // R6: strobe and start write during run are ignored
        run_seq(10'd200, 10'd215, 1'b0, 3'd0, 1'b1, 1'b1);

        // R6: strobe on the same edge as the final read
        gated = 1'b0;
        hw(3'd0, 16'd40);
        hw(3'd1, 16'd45);
        hw(3'd2, 16'h0000);
        push_range(10'd40, 10'd45, 1'b0, 3'd0);
        hw(3'd3, 16'h0001);
        while (!(dm_rd && dm_addr == 10'd45)) @(negedge clk);
        hw(3'd3, 16'h0001);
        check(done == 1'b1, "R6", "done after final read with strobe", done, 1);
        check(seq_owns == 1'b0, "R6", "colliding strobe ignored", seq_owns, 0);
        @(negedge clk);
        check(seq_owns == 1'b0, "R6", "no rearm after collision", seq_owns, 0);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R6", "no extra outputs", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule